// File: doc/BRIEF.md
# Timed Recalibration Scheduler

This block decides when a frequency calibration of a low-speed clock generator may start. It keeps a free-running timer that is cleared each time a calibration reports completion. When the timer reaches a programmable timeout and timed mode is on, the block asks the power controller to wake the crystal. It then waits for the crystal to report itself valid and issues a one-cycle calibration start.

A second, back-to-back mode restarts calibration on the cycle after each completion, for systems that keep the crystal running. Both modes may be enabled at once. Enabling the block always launches one initial calibration. The crystal-valid input is asynchronous. It passes through a two-flop synchronizer, and only its rising edge is used. Software normally loads the timeout with 0x2000000 after reset and keeps it well above the length of one calibration.

Top module: `recal_sched`

## Requirements
- R1: While rst_n is low on a clock edge, xtal_req and cal_start are 0 after that edge.
- R2: On the first edge that samples enable high after it was low, cal_start goes to 1 for exactly one cycle.
- R3: The timer is cleared on every edge that samples cal_done high or enable low. With timed mode on and the block idle, xtal_req rises exactly timeout_val+1 edges after the edge that sampled cal_done, for timeout_val of 0 or more.
- R4: With timer_mode_en low, xtal_req never rises.
- R5: xtal_req stays high until the synchronized rising edge of xtal_valid. On the third edge that samples xtal_valid high, xtal_req falls and cal_start pulses in the same cycle.
- R6: A rising xtal_valid while no request is pending produces no cal_start.
- R7: A timeout reached while a calibration is running produces neither xtal_req nor cal_start.
- R8: With always_mode_en high, the edge that samples cal_done during a calibration also raises cal_start. Setting always_mode_en while idle starts a calibration on the next edge.
- R9: With both modes enabled and calibrations running back to back, xtal_req stays low and each cal_done yields exactly one cal_start.
- R10: An edge that samples enable low clears xtal_req. While enable stays low, no cal_start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; a rising level launches the first calibration |
| timeout_val | input | TW (32) | Timer limit in clock cycles |
| timer_mode_en | input | 1 | Enables timeout-driven crystal wake-up |
| always_mode_en | input | 1 | Enables back-to-back calibration |
| cal_done | input | 1 | One-cycle calibration completion event |
| xtal_valid | input | 1 | Asynchronous crystal-ready level from the power controller |
| xtal_req | output | 1 | Crystal wake request to the power controller |
| cal_start | output | 1 | One-cycle calibration start pulse |

## Verification
All outputs are registered, so each result is due a fixed number of edges after the edge that samples its cause. A start follows enable or cal_done by one edge. A request follows the done edge by timeout_val+1 edges. The handshake completes on the third edge after xtal_valid rises, because two synchronizer flops precede the edge detector. The bench drives and samples one time unit after each rising edge, counts edges from the edge that captured the stimulus, and checks both the cycle just before a result is due and the cycle it arrives. Random timeouts and random valid delays are checked against these counts, computed by bench functions.

// File: rtl/recal_pkg.sv
// Shared types for the recalibration scheduler.
package recal_pkg;
    // Scheduler phases: disabled, idle, calibration running, waiting for crystal.
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_IDLE = 2'd1,
        PH_RUN  = 2'd2,
        PH_WAIT = 2'd3
    } phase_t;
endpackage

// File: rtl/recal_sync_edge.sv
// Multi-flop synchronizer with rising-edge detector.
// Assumes: async_in is a level that stays stable for several clk cycles.
module recal_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;

    // Shift the asynchronous level through the synchronizer stages.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Remember the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;

    // R5: a detected edge lasts one cycle.
    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/recal_timer.sv
// Saturating timeout timer.
// Assumes: clear has priority. The count holds once it reaches the limit.
module recal_timer #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] count;

    // Count up to the limit, restart from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (clear)         count <= '0;
        else if (count < limit) count <= count + ONE;
    end

    assign expired = (count >= limit);

    // R3: a clear always leaves the count at zero.
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> count == '0);
endmodule

// File: rtl/recal_ctrl.sv
// Phase controller that issues calibration starts and crystal requests.
// Assumes: cal_done is a single-cycle pulse and xtal_rise is already synchronous.
module recal_ctrl
    import recal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic timer_mode_en,
    input  logic always_mode_en,
    input  logic cal_done,
    input  logic expired,
    input  logic xtal_rise,
    output logic xtal_req,
    output logic cal_start
);
    phase_t phase;

    // Advance the phase and register both outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OFF;
            xtal_req  <= 1'b0;
            cal_start <= 1'b0;
        end else begin
            cal_start <= 1'b0;
            if (!enable) begin
                phase    <= PH_OFF;
                xtal_req <= 1'b0;
            end else begin
                case (phase)
                    PH_OFF: begin
                        cal_start <= 1'b1;
                        phase     <= PH_RUN;
                    end
                    PH_RUN: begin
                        if (cal_done) begin
                            if (always_mode_en) cal_start <= 1'b1;
                            else                phase     <= PH_IDLE;
                        end
                    end
                    PH_IDLE: begin
                        if (always_mode_en) begin
                            cal_start <= 1'b1;
                            phase     <= PH_RUN;
                        end else if (timer_mode_en && expired) begin
                            xtal_req <= 1'b1;
                            phase    <= PH_WAIT;
                        end
                    end
                    PH_WAIT: begin
                        if (xtal_rise) begin
                            xtal_req  <= 1'b0;
                            cal_start <= 1'b1;
                            phase     <= PH_RUN;
                        end
                    end
                    default: phase <= PH_OFF;
                endcase
            end
        end
    end

    // R4: a request only rises with timed mode on.
    a_r4_req_needs_timer: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xtal_req) |-> $past(timer_mode_en));
    // R5: a request released while enabled hands over to a start.
    a_r5_release_starts: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xtal_req) && $past(enable) |-> cal_start);
    // R5: a start never coexists with a pending request.
    a_r5_start_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        cal_start |-> !xtal_req);
    // R10: nothing is issued after an edge that saw enable low.
    a_r10_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> !cal_start && !xtal_req);
endmodule

// File: rtl/recal_sched.sv
// Top of the recalibration scheduler: timer, crystal-valid synchronizer and controller.
// Assumes: one clock domain apart from xtal_valid.
module recal_sched #(
    parameter int TW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] timeout_val,
    input  logic          timer_mode_en,
    input  logic          always_mode_en,
    input  logic          cal_done,
    input  logic          xtal_valid,
    output logic          xtal_req,
    output logic          cal_start
);
    logic timer_clear;
    logic expired;
    logic xtal_rise;

    assign timer_clear = cal_done | ~enable;

    recal_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (timer_clear),
        .limit   (timeout_val),
        .expired (expired)
    );

    recal_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (xtal_valid),
        .rise     (xtal_rise)
    );

    recal_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .timer_mode_en  (timer_mode_en),
        .always_mode_en (always_mode_en),
        .cal_done       (cal_done),
        .expired        (expired),
        .xtal_rise      (xtal_rise),
        .xtal_req       (xtal_req),
        .cal_start      (cal_start)
    );
endmodule

// File: tb/recal_sched_test.sv
// Self-checking bench: directed corners plus seeded random timeouts and valid delays.
module recal_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] timeout_val = '0;
    logic        timer_mode_en = 1'b0;
    logic        always_mode_en = 1'b0;
    logic        cal_done = 1'b0;
    logic        xtal_valid = 1'b0;
    logic        xtal_req;
    logic        cal_start;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    recal_sched uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .timeout_val(timeout_val),
        .timer_mode_en(timer_mode_en), .always_mode_en(always_mode_en),
        .cal_done(cal_done), .xtal_valid(xtal_valid),
        .xtal_req(xtal_req), .cal_start(cal_start)
    );

    // Edges from the done edge to the request, per R3.
    function automatic int req_delay(input int t);
        return t + 1;
    endfunction

    // Edges from valid rising to the start, per R5 (two sync flops plus the register).
    function automatic int start_delay();
        return 3;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic pulse_done();
        cal_done = 1'b1;
        step();
        cal_done = 1'b0;
    endtask

    task automatic wait_req(input int t, input string rq);
        int n = 0;
        while (!xtal_req && n < 400) begin
            step();
            n++;
        end
        check(n == req_delay(t), rq, n, req_delay(t));
    endtask

    task automatic handshake(input int d);
        int bad = 0;
        for (int i = 0; i < d; i++) begin
            step();
            if (!xtal_req || cal_start) bad++;
        end
        check(bad == 0, "R5 hold", bad, 0);
        xtal_valid = 1'b1;
        for (int i = 0; i < start_delay() - 1; i++) step();
        check(xtal_req && !cal_start, "R5 early", {xtal_req, cal_start}, 2);
        step();
        check(!xtal_req && cal_start, "R5 due", {xtal_req, cal_start}, 1);
        step();
        check(!cal_start, "R5 pulse", cal_start, 0);
        xtal_valid = 1'b0;
    endtask

    initial begin
        int seen;
        void'($urandom(32'd24680));
        repeat (3) step();
        check(!xtal_req && !cal_start, "R1", {xtal_req, cal_start}, 0);
        rst_n = 1'b1;
        step();
        check(!cal_start, "R10 idle off", cal_start, 0);

        // R2: enable launches one start.
        timeout_val = 5;
        timer_mode_en = 1'b1;
        enable = 1'b1;
        step();
        check(cal_start == 1'b1, "R2 start", cal_start, 1);
        step();
        check(cal_start == 1'b0, "R2 single", cal_start, 0);

        // R7: timeout during a run is ignored.
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (xtal_req || cal_start) seen++;
        end
        check(seen == 0, "R7", seen, 0);

        // R3 and R5 with random timeouts and delays.
        for (int k = 0; k < 20; k++) begin
            int t = $urandom_range(3, 60);
            timeout_val = t;
            pulse_done();
            wait_req(t, "R3 random");
            handshake($urandom_range(0, 8));
        end

        // R4: timed mode off yields no request.
        timer_mode_en = 1'b0;
        timeout_val = 3;
        pulse_done();
        seen = 0;
        for (int i = 0; i < 60; i++) begin
            step();
            if (xtal_req) seen++;
        end
        check(seen == 0, "R4", seen, 0);

        // R6: valid without a pending request.
        xtal_valid = 1'b1;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (cal_start) seen++;
        end
        check(seen == 0, "R6", seen, 0);
        xtal_valid = 1'b0;
        repeat (4) step();

        // R8: always mode from idle, then on done.
        always_mode_en = 1'b1;
        step();
        check(cal_start == 1'b1, "R8 from idle", cal_start, 1);
        step();
        check(cal_start == 1'b0, "R8 single", cal_start, 0);
        pulse_done();
        check(cal_start == 1'b1, "R8 on done", cal_start, 1);
        step();

        // R9: both modes, back-to-back runs.
        timer_mode_en = 1'b1;
        timeout_val = 2;
        seen = 0;
        for (int k = 0; k < 5; k++) begin
            for (int i = 0; i < 10; i++) begin
                step();
                if (xtal_req) seen += 100;
                if (cal_start) seen++;
            end
            pulse_done();
            if (xtal_req) seen += 100;
            if (cal_start) seen++;
        end
        check(seen == 5, "R9", seen, 5);

        // R10: disabling clears a pending request.
        always_mode_en = 1'b0;
        timeout_val = 3;
        step();
        pulse_done();
        wait_req(3, "R3 before off");
        enable = 1'b0;
        step();
        check(!xtal_req, "R10 clear", xtal_req, 0);
        xtal_valid = 1'b1;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (cal_start || xtal_req) seen++;
        end
        check(seen == 0, "R10 quiet", seen, 0);
        xtal_valid = 1'b0;
        repeat (4) step();

        // R2 again, then R3 zero-timeout corner.
        enable = 1'b1;
        step();
        check(cal_start == 1'b1, "R2 reenable", cal_start, 1);
        timeout_val = 0;
        step();
        pulse_done();
        wait_req(0, "R3 zero");
        handshake(2);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule